// File: doc/BRIEF.md
# Threshold-Driven Packet Memory Arbiter

This block decides which of three requesters owns a single shared packet memory port: a receive DMA, a transmit DMA and a host port. Each DMA side reports how full its FIFO is. A 2-bit threshold code for each side sets the level at which that side counts as urgent ("critical"). The receive side is urgent when its FIFO is filling past its threshold. The transmit side is urgent when its FIFO is draining below its threshold. The urgency flags reorder the priority between the two DMAs. The host is served only when the memory is otherwise idle.

An access starts with a grant. The grant is held until the memory port reports `mem_done`. The block chooses the next owner only while no grant is outstanding. Both threshold codes sit in one control byte, which is written whole through a write strobe.

Top module: `pkt_mem_arbiter`

## Requirements
- R1: A write with `cfg_we` high loads the transmit threshold code from `cfg_byte[1:0]` and the receive threshold code from `cfg_byte[3:2]`. Bits [7:4] have no effect on either urgency flag.
- R2: After reset both threshold codes are 2'b01, which is half the FIFO depth.
- R3: Threshold code c stands for a level of (c+1)*DEPTH/4 entries. Codes 00, 01, 10 and 11 therefore give a quarter, a half, three quarters and the full depth.
- R4: `rx_crit` is high exactly when `rx_level` is strictly greater than the receive threshold level.
- R5: `tx_crit` is high exactly when `tx_level` is strictly less than the transmit threshold level.
- R6: When both DMAs request and `rx_crit` is high, the receive DMA is granted, whatever the state of `tx_crit`.
- R7: When the transmit DMA requests, `tx_crit` is high, and the receive side is either not requesting or not critical, the transmit DMA is granted.
- R8: When both DMAs request and neither is critical, they alternate. The receive DMA is favoured after reset. Each completed DMA grant hands the preference to the other DMA. Host accesses leave the preference unchanged.
- R9: The host is granted only when neither DMA is requesting. Either DMA request takes precedence over a host request.
- R10: At most one grant is high at a time. A grant appears on the clock edge after a choice is made while idle, and it stays unchanged until `mem_done`. It drops on the edge where `mem_done` is sampled high. `mem_busy` is high exactly while any grant is high. After reset there are no grants.
- R11: A control byte write takes effect from the next clock edge. A choice made on the same edge as the write uses the old thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_byte | input | 8 | Control byte: [1:0] transmit code, [3:2] receive code |
| rx_req | input | 1 | Receive DMA request |
| tx_req | input | 1 | Transmit DMA request |
| host_req | input | 1 | Host request |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| mem_done | input | 1 | Memory port finished the current access |
| rx_gnt | output | 1 | Receive DMA owns the port |
| tx_gnt | output | 1 | Transmit DMA owns the port |
| host_gnt | output | 1 | Host owns the port |
| mem_busy | output | 1 | A grant is outstanding |
| rx_crit | output | 1 | Receive side is urgent |
| tx_crit | output | 1 | Transmit side is urgent |

## Verification
Two events can fall on the same clock edge: a threshold rewrite and an arbitration decision. The bench sets up a case where the old and new receive thresholds give different winners. It writes the control byte on the same edge that both DMAs first raise their requests. The first grant must follow the old thresholds, and the next access must follow the new ones. Around this case, the bench sweeps every pair of threshold codes against every FIFO level. It also runs every request mask under every combination of urgency flags, with the round-robin preference tracked arithmetically in the bench.

// File: rtl/pma_pkg.sv
package pma_pkg;

  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_RX   = 2'd1,
    PICK_TX   = 2'd2,
    PICK_HOST = 2'd3
  } pick_e;

  // Level represented by a 2-bit threshold code: (code+1) quarters of depth.
  function automatic int thr_level(input logic [1:0] code, input int depth);
    return ((int'(code) + 1) * depth) / 4;
  endfunction

endpackage

// File: rtl/pma_cfg_reg.sv
module pma_cfg_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [3:0] cfg_low,
  output logic [1:0] tx_code,
  output logic [1:0] rx_code
);
  localparam logic [1:0] HALF_CODE = 2'b01;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_code <= HALF_CODE;
      rx_code <= HALF_CODE;
    end else if (cfg_we) begin
      tx_code <= cfg_low[1:0];
      rx_code <= cfg_low[3:2];
    end
  end

  // R11: a write lands on the next edge
  a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) |-> (rx_code == $past(cfg_low[3:2]) && tx_code == $past(cfg_low[1:0])));
  // R1: no write, no change
  a_r1_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> ($stable(rx_code) && $stable(tx_code)));

endmodule

// File: rtl/pma_crit.sv
module pma_crit #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter bit IS_RX = 1'b1
) (
  input  logic [LVL_W-1:0] level,
  input  logic [1:0]       code,
  output logic             crit
);
  import pma_pkg::*;

  logic [LVL_W-1:0] thr_q;
  assign thr_q = LVL_W'(thr_level(code, DEPTH));

  generate
    if (IS_RX) begin : g_fill_side
      assign crit = (level > thr_q);
    end else begin : g_drain_side
      assign crit = (level < thr_q);
    end
  endgenerate

endmodule

// File: rtl/pma_grant_fsm.sv
module pma_grant_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_req,
  input  logic tx_req,
  input  logic host_req,
  input  logic rx_crit,
  input  logic tx_crit,
  input  logic mem_done,
  output logic rx_gnt,
  output logic tx_gnt,
  output logic host_gnt
);
  import pma_pkg::*;

  logic [2:0] gnt_q;      // {host, tx, rx}
  logic       pref_tx_q;  // round-robin: 1 favours transmit on a tie
  pick_e      pick;
  logic       idle;
  logic       finish_evt;

  assign idle       = (gnt_q == 3'b000);
  assign finish_evt = !idle && mem_done;

  always_comb begin
    pick = PICK_NONE;
    if (rx_req && tx_req) begin
      if (rx_crit)        pick = PICK_RX;
      else if (tx_crit)   pick = PICK_TX;
      else if (pref_tx_q) pick = PICK_TX;
      else                pick = PICK_RX;
    end else if (rx_req) begin
      pick = PICK_RX;
    end else if (tx_req) begin
      pick = PICK_TX;
    end else if (host_req) begin
      pick = PICK_HOST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q     <= 3'b000;
      pref_tx_q <= 1'b0;
    end else if (idle) begin
      case (pick)
        PICK_RX:   gnt_q <= 3'b001;
        PICK_TX:   gnt_q <= 3'b010;
        PICK_HOST: gnt_q <= 3'b100;
        default:   gnt_q <= 3'b000;
      endcase
    end else if (finish_evt) begin
      gnt_q <= 3'b000;
      if (gnt_q[0]) pref_tx_q <= 1'b1;
      if (gnt_q[1]) pref_tx_q <= 1'b0;
    end
  end

  assign rx_gnt   = gnt_q[0];
  assign tx_gnt   = gnt_q[1];
  assign host_gnt = gnt_q[2];

  a_r10_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_gnt, tx_gnt, rx_gnt}));
  a_r10_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !mem_done) |=> $stable({host_gnt, tx_gnt, rx_gnt}));
  a_r10_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> ({host_gnt, tx_gnt, rx_gnt} == 3'b000));
  a_r6_rx_crit_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && rx_req && rx_crit) |=> rx_gnt);
  a_r7_tx_crit_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && tx_req && tx_crit && !(rx_req && rx_crit)) |=> tx_gnt);
  a_r9_host_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_gnt) |-> $past(!rx_req && !tx_req));

endmodule

// File: rtl/pkt_mem_arbiter.sv
module pkt_mem_arbiter #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_byte,
  input  logic             rx_req,
  input  logic             tx_req,
  input  logic             host_req,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             mem_done,
  output logic             rx_gnt,
  output logic             tx_gnt,
  output logic             host_gnt,
  output logic             mem_busy,
  output logic             rx_crit,
  output logic             tx_crit
);
  logic [1:0] tx_code;
  logic [1:0] rx_code;
  logic       unused_cfg_hi;

  assign unused_cfg_hi = ^cfg_byte[7:4];

  pma_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_low (cfg_byte[3:0]),
    .tx_code (tx_code),
    .rx_code (rx_code)
  );

  pma_crit #(.DEPTH(DEPTH), .LVL_W(LVL_W), .IS_RX(1'b1)) u_rx_crit (
    .level (rx_level),
    .code  (rx_code),
    .crit  (rx_crit)
  );

  pma_crit #(.DEPTH(DEPTH), .LVL_W(LVL_W), .IS_RX(1'b0)) u_tx_crit (
    .level (tx_level),
    .code  (tx_code),
    .crit  (tx_crit)
  );

  pma_grant_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_req   (rx_req),
    .tx_req   (tx_req),
    .host_req (host_req),
    .rx_crit  (rx_crit),
    .tx_crit  (tx_crit),
    .mem_done (mem_done),
    .rx_gnt   (rx_gnt),
    .tx_gnt   (tx_gnt),
    .host_gnt (host_gnt)
  );

  assign mem_busy = rx_gnt | tx_gnt | host_gnt;

  a_r10_busy_matches: assert property (@(posedge clk) disable iff (!rst_n)
    mem_busy == (rx_gnt || tx_gnt || host_gnt));

endmodule

// File: tb/test_pkt_mem_arbiter.sv
module test_pkt_mem_arbiter;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam time CLK_P = 4ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_byte = 8'h00;
  logic rx_req = 1'b0, tx_req = 1'b0, host_req = 1'b0;
  logic [LVL_W-1:0] rx_level = '0, tx_level = '0;
  logic mem_done = 1'b0;
  logic rx_gnt, tx_gnt, host_gnt, mem_busy, rx_crit, tx_crit;

  int n_cmp = 0;
  int n_bad = 0;
  bit exp_pref_tx = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pkt_mem_arbiter #(.DEPTH(DEPTH), .LVL_W(LVL_W)) i_pkt_mem_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_byte(cfg_byte),
    .rx_req(rx_req), .tx_req(tx_req), .host_req(host_req),
    .rx_level(rx_level), .tx_level(tx_level), .mem_done(mem_done),
    .rx_gnt(rx_gnt), .tx_gnt(tx_gnt), .host_gnt(host_gnt),
    .mem_busy(mem_busy), .rx_crit(rx_crit), .tx_crit(tx_crit)
  );

  function automatic int quarter_thr(int code);
    return (DEPTH / 4) * (code + 1);
  endfunction

  // 0 none, 1 rx, 2 tx, 3 host, 7 more than one
  function automatic int gcode();
    int n = int'(rx_gnt) + int'(tx_gnt) + int'(host_gnt);
    if (n > 1) return 7;
    if (rx_gnt) return 1;
    if (tx_gnt) return 2;
    if (host_gnt) return 3;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_cfg(input logic [7:0] b);
    @(negedge clk);
    cfg_byte = b;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Called at a negedge; raises requests now and runs one access.
  task automatic access(input bit r, input bit t, input bit h, input int exp,
                        input string req, input int hold);
    rx_req = r; tx_req = t; host_req = h;
    @(negedge clk);
    cfg_we = 1'b0;
    check(req, gcode(), exp);
    check({req, " busy"}, int'(mem_busy), int'(exp != 0));
    for (int k = 0; k < hold; k++) begin
      rx_level = LVL_W'(k % 2 ? 15 : 1);   // move urgency under the grant
      @(negedge clk);
      check("R10 hold", gcode(), exp);
    end
    mem_done = 1'b1;
    rx_req = 1'b0; tx_req = 1'b0; host_req = 1'b0;
    @(negedge clk);
    mem_done = 1'b0;
    check("R10 release", gcode(), 0);
    check("R10 busy low", int'(mem_busy), 0);
    if (exp == 1) exp_pref_tx = 1'b1;
    if (exp == 2) exp_pref_tx = 1'b0;
  endtask

  function automatic int expect_pick(bit r, bit t, bit h, bit rc, bit tc);
    if (r && t) begin
      if (rc) return 1;
      if (tc) return 2;
      return exp_pref_tx ? 2 : 1;
    end
    if (r) return 1;
    if (t) return 2;
    if (h) return 3;
    return 0;
  endfunction

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset no grant", gcode(), 0);
    check("R10 reset busy", int'(mem_busy), 0);

    // R2: half-depth thresholds after reset (8 entries)
    rx_level = LVL_W'(8); tx_level = LVL_W'(8); #1;
    check("R2 rx at half", int'(rx_crit), 0);
    check("R2 tx at half", int'(tx_crit), 0);
    rx_level = LVL_W'(9); tx_level = LVL_W'(7); #1;
    check("R2 rx above half", int'(rx_crit), 1);
    check("R2 tx below half", int'(tx_crit), 1);

    // R1 R3 R4 R5: every code pair against every level, junk in upper bits
    for (int rc = 0; rc < 4; rc++) begin
      for (int tc = 0; tc < 4; tc++) begin
        write_cfg({4'hA ^ 4'(rc * 5 + tc), 2'(rc), 2'(tc)});
        for (int lv = 0; lv <= DEPTH; lv++) begin
          rx_level = LVL_W'(lv); tx_level = LVL_W'(lv); #1;
          check("R4 R3 R1 rx_crit", int'(rx_crit), int'(lv > quarter_thr(rc)));
          check("R5 R3 R1 tx_crit", int'(tx_crit), int'(lv < quarter_thr(tc)));
        end
      end
    end

    // R6 R7 R8 R9: all request masks under all urgency combinations (thr 8/8)
    write_cfg(8'h05);
    for (int cr = 0; cr < 4; cr++) begin
      for (int m = 0; m < 8; m++) begin
        bit rc = cr[0];
        bit tc = cr[1];
        int e;
        rx_level = LVL_W'(rc ? 12 : 4);
        tx_level = LVL_W'(tc ? 4 : 12);
        e = expect_pick(m[0], m[1], m[2], rc, tc);
        access(m[0], m[1], m[2], e, "R6 R7 R8 R9 pick", 0);
      end
    end

    // R8: consecutive ties alternate, host access leaves preference alone
    rx_level = LVL_W'(4); tx_level = LVL_W'(12);
    for (int k = 0; k < 4; k++)
      access(1'b1, 1'b1, 1'b1, exp_pref_tx ? 2 : 1, "R8 alternate", 0);
    access(1'b0, 1'b0, 1'b1, 3, "R9 host alone", 0);
    access(1'b1, 1'b1, 1'b0, exp_pref_tx ? 2 : 1, "R8 after host", 0);

    // R10: long hold while urgency changes under the grant
    access(1'b0, 1'b1, 1'b0, 2, "R10 long hold", 6);
    access(1'b0, 1'b0, 1'b1, 3, "R10 host hold", 3);

    // R11: write on the decision edge uses the old thresholds
    write_cfg(8'h0F);                 // thr 16/16
    rx_level = LVL_W'(10); tx_level = LVL_W'(10);  // rx not urgent, tx urgent
    cfg_byte = 8'h03;                 // rx code 00 -> thr 4, rx becomes urgent
    cfg_we = 1'b1;
    access(1'b1, 1'b1, 1'b0, 2, "R11 old thresholds", 0);
    rx_level = LVL_W'(10); tx_level = LVL_W'(10);
    access(1'b1, 1'b1, 1'b0, 1, "R11 new thresholds", 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule